// File: doc/BRIEF.md
# Single-Slope ADC Conversion Controller

This block is the digital timing and counting core of a single-slope analog-to-digital converter. A periodic timebase, built from a clock prescaler and a phase counter, alternates between a measurement window and a discharge window. During the measurement window the block enables the external ramp and holds the sampled input. During the discharge window it lets the ramp reset to zero and lets the sample-and-hold track the input again. The external comparator output arrives asynchronously. The block synchronises it and captures how many clock cycles pass from ramp start until the ramp crosses the held input.

At the end of each full period the result is published, together with an over-range status and a sticky data-ready flag, and a one-cycle end-of-conversion pulse is raised. Software-style strobes start and stop the converter, clear the flag, or do a read-and-clear. A skip control can throw away the first result after a restart or an input-channel change. The discharge window must last more clock cycles than the synchroniser latency, which means DIV*PWM_LO must be at least 3.

Top module: `ss_adc_ctrl`

## Requirements
- R1: A `start` strobe sampled at a clock edge makes `ramp_en` high from the next cycle. `ramp_en` then stays high for exactly DIV*PWM_HI cycles and low for exactly DIV*PWM_LO cycles, and this pattern repeats until `stop`.
- R2: `sh_hold` is 1 (hold) in every cycle where `ramp_en` is 1. It is 0 (track) in discharge cycles and while idle.
- R3: Number the measurement cycles t = 0, 1, 2, ... from the first ramp cycle. The published `result` is the t of the first cycle at whose closing edge `cmp_in` is 0. The two-cycle synchroniser delay is already subtracted.
- R4: A trip in the last measurement cycle gives `result` = DIV*PWM_HI-1 with `over_range` = 0. This holds even when the full-scale count DIV*PWM_HI is not a power of two.
- R5: If `cmp_in` never reads 0 during the measurement window, the published `result` is 16'hFFFF and `over_range` is 1. Both values are held until the next published result.
- R6: At the end of the last discharge cycle the block publishes the result. `eoc` is high for exactly one cycle and `data_avail` becomes 1. Both are visible in the first cycle of the next measurement window.
- R7: `data_avail` stays 1 until a `clr_flag` or `rd_clr` strobe clears it. Neither strobe changes `result` or `over_range`. If a publish and a clear fall on the same edge, the publish wins.
- R8: While `skip_first` is 1, a `start` or a `chan_chg` strobe arms a discard of the next result. For that result there is no `eoc` and no `data_avail` set, and `result` is left unchanged. The result after it is published normally.
- R9: A `stop` strobe returns the block to idle. `ramp_en` and `sh_hold` are 0 from the next cycle, and no `eoc` appears until the next `start`. If `stop` and `start` arrive together, `stop` wins.
- R10: During and after reset, `ramp_en`, `sh_hold`, `eoc`, `data_avail` and `over_range` are 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Data clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Strobe: begin (or restart) conversions |
| stop | input | 1 | Strobe: return to idle |
| skip_first | input | 1 | Level: arm a discard on start or channel change |
| chan_chg | input | 1 | Strobe: input source has changed |
| cmp_in | input | 1 | Asynchronous comparator output, 1 while ramp is below input |
| clr_flag | input | 1 | Strobe: clear data-available flag |
| rd_clr | input | 1 | Strobe: read result and clear flag |
| ramp_en | output | 1 | 1 = ramp runs, 0 = ramp discharged |
| sh_hold | output | 1 | 1 = hold input, 0 = track |
| result | output | 16 | Last published count, 16'hFFFF when over range |
| over_range | output | 1 | Last published conversion did not trip |
| data_avail | output | 1 | Sticky data-available flag |
| eoc | output | 1 | One-cycle end-of-conversion pulse |

## Verification
The bench builds the block with DIV=5, PWM_HI=4 and PWM_LO=2. That gives a 20-count full scale, which is not a power of two, and a 30-cycle period. With these values every window edge, the last-cycle trip, the over-range case and a double-period discard all occur within a few hundred cycles. The prescaler wraps several times inside each phase, so the bench also exercises the case where prescaler and phase counter roll over on the same edge.

// File: rtl/ssadc_pkg.sv
package ssadc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_MEAS  = 2'd1,
    PH_DISCH = 2'd2
  } ssadc_phase_e;

  localparam int SYNC_STAGES = 2;
  localparam int RES_W       = 16;
  localparam logic [RES_W-1:0] OVR_CODE = '1;
endpackage

// File: rtl/ssadc_timebase.sv
module ssadc_timebase
  import ssadc_pkg::*;
#(
  parameter int DIV     = 256,
  parameter int PWM_HI  = 4,
  parameter int PWM_LO  = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         stop_i,
  output ssadc_phase_e phase_o,
  output logic         ramp_go_o,
  output logic         term_o
);
  localparam int PRE_W  = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int SEGMAX = (PWM_HI > PWM_LO) ? PWM_HI : PWM_LO;
  localparam int SEG_W  = (SEGMAX > 1) ? $clog2(SEGMAX) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV - 1);
  localparam logic [SEG_W-1:0] HI_LAST  = SEG_W'(PWM_HI - 1);
  localparam logic [SEG_W-1:0] LO_LAST  = SEG_W'(PWM_LO - 1);

  ssadc_phase_e     phase_q, phase_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [SEG_W-1:0] seg_q, seg_d;
  logic             tick;
  logic             run_en;

  assign tick   = (pre_q == PRE_LAST);
  assign run_en = (phase_q != PH_IDLE) || start_i || stop_i;

  always_comb begin
    phase_d   = phase_q;
    pre_d     = pre_q;
    seg_d     = seg_q;
    ramp_go_o = 1'b0;
    term_o    = 1'b0;
    if (stop_i) begin
      phase_d = PH_IDLE;
      pre_d   = '0;
      seg_d   = '0;
    end else if (start_i) begin
      phase_d   = PH_MEAS;
      pre_d     = '0;
      seg_d     = '0;
      ramp_go_o = 1'b1;
    end else begin
      case (phase_q)
        PH_MEAS: begin
          pre_d = tick ? '0 : pre_q + 1'b1;
          if (tick) begin
            if (seg_q == HI_LAST) begin
              phase_d = PH_DISCH;
              seg_d   = '0;
            end else begin
              seg_d = seg_q + 1'b1;
            end
          end
        end
        PH_DISCH: begin
          pre_d = tick ? '0 : pre_q + 1'b1;
          if (tick) begin
            if (seg_q == LO_LAST) begin
              phase_d   = PH_MEAS;
              seg_d     = '0;
              ramp_go_o = 1'b1;
              term_o    = 1'b1;
            end else begin
              seg_d = seg_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      pre_q   <= '0;
      seg_q   <= '0;
    end else if (run_en) begin
      phase_q <= phase_d;
      pre_q   <= pre_d;
      seg_q   <= seg_d;
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/ssadc_sync.sv
module ssadc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '1;
    end else begin
      sh_q <= {sh_q[STAGES-2:0], d_i};
    end
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/ssadc_capture.sv
module ssadc_capture
  import ssadc_pkg::*;
#(
  parameter int MEAS = 1024,
  parameter int LAT  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ramp_go_i,
  input  logic             stop_i,
  input  logic             cmp_s_i,
  output logic             tripped_o,
  output logic [RES_W-1:0] count_o
);
  localparam int SAT_V = MEAS + LAT;
  localparam int EL_W  = $clog2(SAT_V + 1);
  localparam logic [EL_W-1:0] SAT   = EL_W'(SAT_V);
  localparam logic [EL_W-1:0] WOPEN = EL_W'(LAT);

  logic [EL_W-1:0]  el_q, el_d;
  logic             trip_q, trip_d;
  logic [RES_W-1:0] cap_q, cap_d;
  logic             in_win;

  assign in_win = (el_q >= WOPEN) && (el_q < SAT);

  always_comb begin
    el_d   = el_q;
    trip_d = trip_q;
    cap_d  = cap_q;
    if (ramp_go_i) begin
      el_d   = '0;
      trip_d = 1'b0;
    end else if (stop_i) begin
      el_d   = SAT;
      trip_d = 1'b0;
    end else begin
      if (el_q != SAT) el_d = el_q + 1'b1;
      if (in_win && !cmp_s_i && !trip_q) begin
        trip_d = 1'b1;
        cap_d  = RES_W'(el_q - WOPEN);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      el_q   <= SAT;
      trip_q <= 1'b0;
      cap_q  <= '0;
    end else begin
      el_q   <= el_d;
      trip_q <= trip_d;
      cap_q  <= cap_d;
    end
  end

  assign tripped_o = trip_q;
  assign count_o   = cap_q;
endmodule

// File: rtl/ss_adc_ctrl.sv
module ss_adc_ctrl
  import ssadc_pkg::*;
#(
  parameter int DIV    = 256,
  parameter int PWM_HI = 4,
  parameter int PWM_LO = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic              skip_first,
  input  logic              chan_chg,
  input  logic              cmp_in,
  input  logic              clr_flag,
  input  logic              rd_clr,
  output logic              ramp_en,
  output logic              sh_hold,
  output logic [RES_W-1:0]  result,
  output logic              over_range,
  output logic              data_avail,
  output logic              eoc
);
  localparam int MEAS = DIV * PWM_HI;

  ssadc_phase_e     phase;
  logic             ramp_go, term;
  logic             cmp_s;
  logic             tripped;
  logic [RES_W-1:0] count;

  ssadc_timebase #(.DIV(DIV), .PWM_HI(PWM_HI), .PWM_LO(PWM_LO)) u_tb (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .stop_i    (stop),
    .phase_o   (phase),
    .ramp_go_o (ramp_go),
    .term_o    (term)
  );

  ssadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (cmp_in),
    .q_o   (cmp_s)
  );

  ssadc_capture #(.MEAS(MEAS), .LAT(SYNC_STAGES)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .ramp_go_i (ramp_go),
    .stop_i    (stop),
    .cmp_s_i   (cmp_s),
    .tripped_o (tripped),
    .count_o   (count)
  );

  logic [RES_W-1:0] res_q, res_d;
  logic             ovr_q, ovr_d;
  logic             avail_q, avail_d;
  logic             eoc_q, eoc_d;
  logic             skip_q, skip_d;
  logic             publish;
  logic             arm;

  assign publish = term && !skip_q;
  assign arm     = skip_first && ((start && !stop) || chan_chg);

  always_comb begin
    res_d   = res_q;
    ovr_d   = ovr_q;
    avail_d = avail_q;
    skip_d  = skip_q;
    eoc_d   = publish;
    if (term) skip_d = 1'b0;
    if (arm)  skip_d = 1'b1;
    if (clr_flag || rd_clr) avail_d = 1'b0;
    if (publish) begin
      res_d   = tripped ? count : OVR_CODE;
      ovr_d   = !tripped;
      avail_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      ovr_q   <= 1'b0;
      avail_q <= 1'b0;
      eoc_q   <= 1'b0;
      skip_q  <= 1'b0;
    end else begin
      if (publish) begin
        res_q <= res_d;
        ovr_q <= ovr_d;
      end
      avail_q <= avail_d;
      eoc_q   <= eoc_d;
      skip_q  <= skip_d;
    end
  end

  assign ramp_en    = (phase == PH_MEAS);
  assign sh_hold    = (phase == PH_MEAS);
  assign result     = res_q;
  assign over_range = ovr_q;
  assign data_avail = avail_q;
  assign eoc        = eoc_q;
endmodule

// File: rtl/ss_adc_ctrl_chk.sv
module ss_adc_ctrl_chk #(
  parameter int MEAS = 1024
) (
  input logic        clk,
  input logic        rst_n,
  input logic        stop,
  input logic        clr_flag,
  input logic        rd_clr,
  input logic        ramp_en,
  input logic        sh_hold,
  input logic [15:0] result,
  input logic        over_range,
  input logic        data_avail,
  input logic        eoc
);
  AST_HOLD_IN_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_en |-> sh_hold); // R2
  AST_OVR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    over_range |-> (result == 16'hFFFF)); // R5
  AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!over_range && data_avail) |-> (32'(result) < MEAS)); // R4
  AST_EOC_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> data_avail); // R6
  AST_EOC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> !eoc); // R6
  AST_EOC_AFTER_DISCH: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> $past(!ramp_en)); // R6
  AST_FLAG_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_avail) |-> $past(clr_flag || rd_clr)); // R7
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!ramp_en && !sh_hold)); // R9
endmodule

bind ss_adc_ctrl ss_adc_ctrl_chk #(.MEAS(MEAS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stop       (stop),
  .clr_flag   (clr_flag),
  .rd_clr     (rd_clr),
  .ramp_en    (ramp_en),
  .sh_hold    (sh_hold),
  .result     (result),
  .over_range (over_range),
  .data_avail (data_avail),
  .eoc        (eoc)
);

// File: tb/ss_adc_ctrl_test.sv
`timescale 1ns/1ps
module ss_adc_ctrl_test;
  localparam int DIV  = 5;
  localparam int HI   = 4;
  localparam int LO   = 2;
  localparam int MEAS = DIV * HI;
  localparam int DISC = DIV * LO;
  localparam int NV   = 7;
  localparam int VTHR [NV] = '{0, 7, 13, 19, 20, 31, 1};
  localparam int VRES [NV] = '{0, 7, 13, 19, 65535, 65535, 1};
  localparam int VOVR [NV] = '{0, 0, 0, 0, 1, 1, 0};

  logic clk = 1'b0;
  logic rst_n, start, stop, skip_first, chan_chg, clr_flag, rd_clr;
  logic cmp_in = 1'b1;
  logic ramp_en, sh_hold, over_range, data_avail, eoc;
  logic [15:0] result;

  int n_tests = 0;
  int n_fail  = 0;
  int thr     = 1000;
  int rc      = 0;
  int cyc     = 0;

  ss_adc_ctrl #(.DIV(DIV), .PWM_HI(HI), .PWM_LO(LO)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .skip_first(skip_first), .chan_chg(chan_chg), .cmp_in(cmp_in),
    .clr_flag(clr_flag), .rd_clr(rd_clr), .ramp_en(ramp_en),
    .sh_hold(sh_hold), .result(result), .over_range(over_range),
    .data_avail(data_avail), .eoc(eoc)
  );

  always #5 clk = ~clk;

  // comparator model: low once the ramp cycle index reaches thr
  always @(negedge clk) begin
    if (ramp_en) begin
      cmp_in <= !(rc >= thr);
      rc = rc + 1;
    end else begin
      cmp_in <= 1'b1;
      rc = 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog R1: actual %0d cycles, expected fewer than 100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_eoc();
    for (int i = 0; i < 200; i++) begin
      if (eoc) return;
      @(negedge clk);
    end
  endtask

  task automatic pulse_start();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  initial begin
    int n;
    int saved;
    rst_n = 1'b0; start = 0; stop = 0; skip_first = 0; chan_chg = 0;
    clr_flag = 0; rd_clr = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!ramp_en && !sh_hold && !eoc && !data_avail && !over_range && result == 0,
        "R10", int'(result), 0);
    rst_n = 1'b1;
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (ramp_en || eoc) n++;
    end
    chk(n == 0, "R9 idle", n, 0);

    // R1/R2/R5/R6: window lengths with an untripped comparator
    thr = 1000;
    pulse_start();
    n = 0;
    while (ramp_en && n < 100) begin
      if (!sh_hold) n = n + 1000;
      n++; @(negedge clk);
    end
    chk(n == MEAS, "R1 R2 high window", n, MEAS);
    n = 0;
    while (!ramp_en && n < 100) begin
      if (sh_hold) n = n + 1000;
      n++; @(negedge clk);
    end
    chk(n == DISC, "R1 R2 low window", n, DISC);
    chk(eoc && data_avail, "R6 eoc at window start", int'(eoc), 1);
    chk(result == 16'hFFFF && over_range, "R5 over range", int'(result), 65535);
    @(negedge clk);
    chk(!eoc, "R6 single pulse", int'(eoc), 0);

    // vector table: R3, R4, R5, R7
    for (int v = 0; v < NV; v++) begin
      thr = VTHR[v];
      wait_eoc(); @(negedge clk); wait_eoc();
      chk(int'(result) == VRES[v], "R3 R4 R5 result", int'(result), VRES[v]);
      chk(int'(over_range) == VOVR[v], "R4 R5 status", int'(over_range), VOVR[v]);
      saved = int'(result);
      rd_clr = 1'b1; @(negedge clk); rd_clr = 1'b0;
      chk(!data_avail && int'(result) == saved, "R7 read-and-clear", int'(result), saved);
    end

    // R7 explicit clear
    wait_eoc();
    saved = int'(result);
    @(negedge clk);
    chk(data_avail, "R7 sticky", int'(data_avail), 1);
    clr_flag = 1'b1; @(negedge clk); clr_flag = 1'b0;
    chk(!data_avail && int'(result) == saved, "R7 clear", int'(data_avail), 0);

    // R9 stop
    stop = 1'b1; @(negedge clk); stop = 1'b0;
    chk(!ramp_en && !sh_hold, "R9 stop", int'(ramp_en), 0);
    n = 0;
    for (int i = 0; i < 70; i++) begin
      @(negedge clk);
      if (ramp_en || eoc) n++;
    end
    chk(n == 0, "R9 stays idle", n, 0);

    // R8 discard after start
    thr = 7; skip_first = 1'b1;
    pulse_start();
    n = 0;
    while (!eoc && n < 200) begin
      if (n == 2 * (MEAS + DISC) - 5 && data_avail) n = n + 1000;
      n++; @(negedge clk);
    end
    chk(n == 2 * (MEAS + DISC), "R8 discard after start", n, 2 * (MEAS + DISC));
    chk(int'(result) == 7 && !over_range, "R8 R3 second result", int'(result), 7);

    // R8 discard after channel change
    chan_chg = 1'b1; thr = 3; @(negedge clk); chan_chg = 1'b0;
    n = 0;
    while (!eoc && n < 200) begin
      n++; @(negedge clk);
    end
    chk(n == 2 * (MEAS + DISC) - 1, "R8 discard after chan_chg", n, 2 * (MEAS + DISC) - 1);
    chk(int'(result) == 3, "R8 R3 result after chan_chg", int'(result), 3);
    skip_first = 1'b0;

    // R9 stop wins over start
    start = 1'b1; stop = 1'b1; @(negedge clk); start = 1'b0; stop = 1'b0;
    chk(!ramp_en, "R9 stop priority", int'(ramp_en), 0);
    @(negedge clk);
    chk(!ramp_en && !eoc, "R9 stop priority hold", int'(ramp_en), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule